// File: doc/BRIEF.md
# Memory-Mapped SPI Master Controller

This block is an SPI master that a processor programs through a simple read/write port holding five 32-bit registers, one per word offset. Software chooses target devices with a one-hot slave-select mask and then writes a word to the transmit register. The block moves that word into its shift engine and clocks it out MSB first while it samples the serial input. When the exchange ends, the received word lands in the receive register and a ready flag is raised.

A one-word holding register sits in front of the shift engine, so software can queue the next word while the current one is still shifting. Sticky flags record two kinds of misuse. One is a completed word arriving while the previous received word is still unread. The other is a transmit write that arrives while the holding register is still full. A summary error flag ORs the two together. Each flag except shifter-empty has its own interrupt enable, and the single interrupt output is the OR of all enabled, active flags. A control bit holds the selected chip-selects low between words, so that multi-word frames stay framed.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, the status register reads 0x060 (shifter-empty bit 5 and transmit-ready bit 6 set). Control and slave-select read 0. All `cs_n_o` lines are high, `sclk_o` is low and `irq_o` is low.
- R2: A write to byte offset 4 starts one full-duplex exchange of DATA_W bits. When it ends, the received word is readable at offset 0 and receive-ready (status bit 7) is set.
- R3: SPI mode 0 timing is used. `sclk_o` idles low, `miso_i` is sampled on the rising edge, `mosi_o` changes only on the falling edge, bits go MSB first, and each SCLK half period lasts CLK_DIV clock cycles.
- R4: The slave-select register at offset 20 is a mask in which bit n selects device n. With the force bit clear, `cs_n_o[n]` is low only while a word is shifting and only when mask bit n is set.
- R5: Reading offset 0 clears receive-ready, unless a new word completes in the same cycle.
- R6: Control bit 10 (force) drives low every `cs_n_o` line whose mask bit is set, also while no word is shifting.
- R7: If a word completes while receive-ready is still set, receive-overrun (status bit 3) is set and the unread word is kept.
- R8: Any write to the status register at offset 8 clears receive-overrun and transmit-overrun and leaves receive-ready unchanged. Status bit 8 is the OR of the two overrun flags.
- R9: A transmit write while transmit-ready is low sets transmit-overrun (status bit 4), and that word is discarded.
- R10: `irq_o` is high exactly when some status bit among 3, 4, 6, 7 and 8 is set together with the control bit of the same number.
- R11: Only control bits 3, 4, 6, 7, 8 and 10 are stored; other control bits read 0. Offsets other than 0, 8, 12 and 20 read as 0.
- R12: Transmit-ready (bit 6) means the holding register is empty. Shifter-empty (bit 5) means the holding register is empty and no word is shifting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a read at offset 0 consumes the received word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, valid in the same cycle |
| irq_o | output | 1 | Interrupt request, level |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the devices |
| miso_i | input | 1 | Serial data from the devices |
| cs_n_o | output | NCS | Active-low chip selects, one per device |

## Verification
The bench builds the block with DATA_W = 8, NCS = 4 and CLK_DIV = 2, so one word takes 32 clock cycles. This keeps back-to-back exchanges and both overrun paths short enough to run many times. A bench-side slave rotates a known byte on each falling SCLK edge and records `mosi_o` on each rising edge. This checks bit order, sampling edge and the received value at the same time. Transmit writes spaced two cycles apart let the holding register refill once and then overflow, and the discarded word is shown by what appears on the wire.

// File: rtl/spim_pkg.sv
// Shared constants for the SPI master: word indices of the registers,
// status/control bit positions and the masks derived from them.
package spim_pkg;

    // Register word index = byte offset / 4
    localparam logic [2:0] IDX_RX   = 3'd0;
    localparam logic [2:0] IDX_TX   = 3'd1;
    localparam logic [2:0] IDX_STS  = 3'd2;
    localparam logic [2:0] IDX_CTRL = 3'd3;
    localparam logic [2:0] IDX_SS   = 3'd5;

    // Status bit positions (control enables use the same numbers)
    localparam int B_ROE   = 3;
    localparam int B_TOE   = 4;
    localparam int B_TMT   = 5;
    localparam int B_TRDY  = 6;
    localparam int B_RRDY  = 7;
    localparam int B_ERR   = 8;
    localparam int B_FORCE = 10;

    localparam int STS_W  = 9;
    localparam int CTRL_W = 11;

    // Bits that may raise an interrupt, and bits the control register keeps
    localparam logic [STS_W-1:0]  IRQ_MASK   = STS_W'((1 << B_ROE) | (1 << B_TOE) |
                                                      (1 << B_TRDY) | (1 << B_RRDY) |
                                                      (1 << B_ERR));
    localparam logic [CTRL_W-1:0] CTRL_WMASK = CTRL_W'(IRQ_MASK) | CTRL_W'(1 << B_FORCE);

endpackage

// File: rtl/spim_shift_eng.sv
// Mode-0 shift engine with its own SCLK divider.
// Assumes start_i is only honoured while idle; the word is shifted MSB first.
// Each SCLK half period lasts CLK_DIV clocks. done_o pulses for one cycle
// after the last falling edge, and rx_o then holds the received word.
module spim_shift_eng #(
    parameter int DATA_W  = 8,
    parameter int CLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              miso_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rx_o,
    output logic              sclk_o,
    output logic              mosi_o
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [DIV_W-1:0] LAST_DIV = DIV_W'(CLK_DIV - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;
    logic [DIV_W-1:0]  div_q;
    logic [BIT_W-1:0]  bit_q;

    // Sequence one word: rise samples MISO, fall advances MOSI
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            sclk_o <= 1'b0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            div_q  <= '0;
            bit_q  <= '0;
        end else begin
            done_o <= 1'b0;
            if (!busy_o) begin
                if (start_i) begin
                    busy_o <= 1'b1;
                    tx_sh  <= data_i;
                    div_q  <= '0;
                    bit_q  <= '0;
                    sclk_o <= 1'b0;
                end
            end else if (div_q == LAST_DIV) begin
                div_q <= '0;
                if (!sclk_o) begin
                    sclk_o <= 1'b1;
                    rx_sh  <= {rx_sh[DATA_W-2:0], miso_i};
                end else begin
                    sclk_o <= 1'b0;
                    if (bit_q == LAST_BIT) begin
                        busy_o <= 1'b0;
                        done_o <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 1'b1;
                        tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
                    end
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign mosi_o = tx_sh[DATA_W-1];
    assign rx_o   = rx_sh;

    // R3
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !sclk_o);

    // R3
    mosi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $rose(sclk_o)) |-> $stable(mosi_o));

endmodule

// File: rtl/spim_csel.sv
// Chip-select driver: a mask line goes low while a word shifts, or at any
// time while the force request is set. Assumes the mask is held stable
// by the register file during a transfer.
module spim_csel #(
    parameter int NCS = 4
) (
    input  logic [NCS-1:0] mask_i,
    input  logic           force_i,
    input  logic           busy_i,
    output logic [NCS-1:0] cs_n_o
);
    logic active;

    // Decide whether the selected lines are driven active
    always_comb begin
        active = force_i | busy_i;
        cs_n_o = ~(mask_i & {NCS{active}});
    end

endmodule

// File: rtl/spim_ctrl.sv
// SPI master register file and top level. Holds the receive word, the
// one-word transmit holding register, the sticky flags, the control and
// slave-select registers, and drives the interrupt. Assumes bus_wr and
// bus_rd are single-cycle strobes and reads are taken in the same cycle.
module spim_ctrl #(
    parameter int DATA_W  = 8,
    parameter int NCS     = 4,
    parameter int CLK_DIV = 2,
    parameter int ADDR_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_o,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic [NCS-1:0]    cs_n_o
);
    import spim_pkg::*;

    logic [2:0]              idx;
    logic                    hit;
    logic                    wr_tx, wr_sts, wr_ctrl, wr_ss, rd_rx;
    logic [DATA_W-1:0]       hold_q, rx_q;
    logic                    hold_full, rrdy, roe, toe;
    logic [CTRL_W-1:0]       ctrl_q;
    logic [NCS-1:0]          ss_q;
    logic [STS_W-1:0]        sts;
    logic                    start, eng_busy, eng_done;
    logic [DATA_W-1:0]       eng_rx;
    logic                    wdata_unused;

    assign wdata_unused = ^bus_wdata;

    // Decode the register selected by the word address
    always_comb begin
        idx     = bus_addr[4:2];
        hit     = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 5) == '0);
        wr_tx   = bus_wr && hit && (idx == IDX_TX);
        wr_sts  = bus_wr && hit && (idx == IDX_STS);
        wr_ctrl = bus_wr && hit && (idx == IDX_CTRL);
        wr_ss   = bus_wr && hit && (idx == IDX_SS);
        rd_rx   = bus_rd && hit && (idx == IDX_RX);
    end

    assign start = hold_full && !eng_busy;

    // Fill the holding register and flag writes made while it is full
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
            toe       <= 1'b0;
        end else begin
            if (start)
                hold_full <= 1'b0;
            if (wr_tx && !hold_full) begin
                hold_q    <= bus_wdata[DATA_W-1:0];
                hold_full <= 1'b1;
            end
            if (wr_tx && hold_full)
                toe <= 1'b1;
            else if (wr_sts)
                toe <= 1'b0;
        end
    end

    // Capture completed words and track receive-ready and receive overrun
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q <= '0;
            rrdy <= 1'b0;
            roe  <= 1'b0;
        end else begin
            rrdy <= eng_done || (rrdy && !rd_rx);
            if (eng_done && (!rrdy || rd_rx))
                rx_q <= eng_rx;
            if (eng_done && rrdy && !rd_rx)
                roe <= 1'b1;
            else if (wr_sts)
                roe <= 1'b0;
        end
    end

    // Store the control enables/force bit and the slave-select mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            ss_q   <= '0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= bus_wdata[CTRL_W-1:0] & CTRL_WMASK;
            if (wr_ss)
                ss_q <= bus_wdata[NCS-1:0];
        end
    end

    // Assemble the status vector
    always_comb begin
        sts         = '0;
        sts[B_ROE]  = roe;
        sts[B_TOE]  = toe;
        sts[B_TMT]  = !hold_full && !eng_busy;
        sts[B_TRDY] = !hold_full;
        sts[B_RRDY] = rrdy;
        sts[B_ERR]  = roe || toe;
    end

    assign irq_o = |(sts & ctrl_q[STS_W-1:0] & IRQ_MASK);

    // Return the addressed register; unmapped offsets read zero
    always_comb begin
        bus_rdata = '0;
        if (hit) begin
            case (idx)
                IDX_RX:   bus_rdata = 32'(rx_q);
                IDX_STS:  bus_rdata = 32'(sts);
                IDX_CTRL: bus_rdata = 32'(ctrl_q);
                IDX_SS:   bus_rdata = 32'(ss_q);
                default:  bus_rdata = '0;
            endcase
        end
    end

    spim_shift_eng #(
        .DATA_W  (DATA_W),
        .CLK_DIV (CLK_DIV)
    ) eng_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .data_i  (hold_q),
        .miso_i  (miso_i),
        .busy_o  (eng_busy),
        .done_o  (eng_done),
        .rx_o    (eng_rx),
        .sclk_o  (sclk_o),
        .mosi_o  (mosi_o)
    );

    spim_csel #(
        .NCS (NCS)
    ) csel_i (
        .mask_i  (ss_q),
        .force_i (ctrl_q[B_FORCE]),
        .busy_i  (eng_busy),
        .cs_n_o  (cs_n_o)
    );

    // R2
    done_sets_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> rrdy);

    // R5
    rx_read_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && !eng_done) |=> !rrdy);

    // R9
    tx_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && !sts[B_TRDY]) |=> toe);

    // R8
    sts_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && !eng_done && !wr_tx) |=> (!roe && !toe));

endmodule

// File: tb/spim_ctrl_tb.sv
`timescale 1ns/1ps
// Directed bench for spim_ctrl: one task per scenario with a rotating
// bench-side slave on MISO and a capture register on MOSI.
module spim_ctrl_tb_top;
    localparam int DATA_W  = 8;
    localparam int NCS     = 4;
    localparam int CLK_DIV = 2;
    localparam int ADDR_W  = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              irq_o, sclk_o, mosi_o, miso_i;
    logic [NCS-1:0]    cs_n_o;

    logic [DATA_W-1:0] slave_sh = '0;
    logic [DATA_W-1:0] mosi_cap = '0;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    spim_ctrl #(.DATA_W(DATA_W), .NCS(NCS), .CLK_DIV(CLK_DIV), .ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o), .sclk_o(sclk_o),
        .mosi_o(mosi_o), .miso_i(miso_i), .cs_n_o(cs_n_o)
    );

    // Slave: presents MSB, rotates on each falling SCLK edge
    assign miso_i = slave_sh[DATA_W-1];
    always @(negedge sclk_o) slave_sh <= {slave_sh[DATA_W-2:0], slave_sh[DATA_W-1]};
    // Record what the master drives at each rising SCLK edge
    always @(posedge sclk_o) mosi_cap <= {mosi_cap[DATA_W-2:0], mosi_o};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        s = '0;
        for (int i = 0; i < 500; i++) begin
            bus_read(5'd8, s);
            if (s[5]) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic test_reset();
        logic [31:0] d;
        bus_read(5'd8, d);  chk("R1 status", d, 32'h060);
        bus_read(5'd12, d); chk("R1 control", d, 32'h0);
        bus_read(5'd20, d); chk("R1 slave select", d, 32'h0);
        chk("R1 cs_n", 32'(cs_n_o), 32'hF);
        chk("R1 sclk/irq", {30'd0, sclk_o, irq_o}, 32'h0);
    endtask

    task automatic test_basic();
        logic [31:0] d;
        bus_write(5'd20, 32'h4);
        bus_read(5'd20, d); chk("R4 mask readback", d, 32'h4);
        slave_sh = 8'h3C;
        bus_write(5'd4, 32'hA5);
        repeat (6) @(negedge clk);
        chk("R4 cs_n during word", 32'(cs_n_o), 32'hB);
        wait_idle();
        chk("R4 cs_n after word", 32'(cs_n_o), 32'hF);
        chk("R3 mosi msb first", 32'(mosi_cap), 32'hA5);
        chk("R3 sclk idle low", 32'(sclk_o), 32'h0);
        bus_read(5'd8, d); chk("R2 rrdy set", 32'(d[7]), 32'h1);
        bus_read(5'd0, d); chk("R2 rx word", d, 32'h3C);
        bus_read(5'd8, d); chk("R5 rrdy cleared", d, 32'h060);
    endtask

    task automatic test_force();
        bus_write(5'd12, 32'h400);
        repeat (2) @(negedge clk);
        chk("R6 forced cs", 32'(cs_n_o), 32'hB);
        bus_write(5'd12, 32'h0);
        chk("R6 released cs", 32'(cs_n_o), 32'hF);
    endtask

    task automatic test_rx_ovf();
        logic [31:0] d;
        slave_sh = 8'h5A;
        bus_write(5'd4, 32'h01);
        wait_idle();
        slave_sh = 8'h81;
        bus_write(5'd4, 32'h02);
        wait_idle();
        bus_read(5'd8, d); chk("R7 roe/err/rrdy", d & 32'h188, 32'h188);
        bus_write(5'd8, 32'h0);
        bus_read(5'd8, d); chk("R8 flags cleared", d & 32'h118, 32'h0);
        chk("R8 rrdy kept", 32'(d[7]), 32'h1);
        bus_read(5'd0, d); chk("R7 unread word kept", d, 32'h5A);
    endtask

    task automatic test_tx_ovf();
        logic [31:0] d;
        slave_sh = 8'h11;
        bus_write(5'd4, 32'h12);
        bus_write(5'd4, 32'h34);
        bus_write(5'd4, 32'h56);
        bus_read(5'd8, d); chk("R9 R12 toe, busy, full", d & 32'h170, 32'h110);
        wait_idle();
        wait_idle();
        chk("R9 dropped word not sent", 32'(mosi_cap), 32'h34);
        bus_write(5'd8, 32'h0);
        bus_read(5'd0, d); chk("R2 rx after back-to-back", d, 32'h11);
        bus_read(5'd8, d); chk("R12 idle status", d, 32'h060);
    endtask

    task automatic test_irq();
        logic [31:0] d;
        bus_write(5'd12, 32'h80);
        chk("R10 irq idle", 32'(irq_o), 32'h0);
        slave_sh = 8'hC3;
        bus_write(5'd4, 32'h77);
        wait_idle();
        chk("R10 irq on rrdy", 32'(irq_o), 32'h1);
        bus_read(5'd0, d);
        chk("R10 irq after read", 32'(irq_o), 32'h0);
        bus_write(5'd12, 32'h40);
        chk("R10 irq on trdy", 32'(irq_o), 32'h1);
        bus_write(5'd12, 32'h0);
        chk("R10 irq disabled", 32'(irq_o), 32'h0);
    endtask

    task automatic test_map();
        logic [31:0] d;
        bus_write(5'd12, 32'hFFFF_FFFF);
        bus_read(5'd12, d); chk("R11 control mask", d, 32'h5D8);
        bus_write(5'd12, 32'h0);
        bus_read(5'd16, d); chk("R11 unmapped 16", d, 32'h0);
        bus_read(5'd4, d);  chk("R11 tx reads zero", d, 32'h0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_basic();
        test_force();
        test_rx_ovf();
        test_tx_ovf();
        test_irq();
        test_map();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule